// File: doc/BRIEF.md
# RTC Alarm and Interrupt Controller

This block holds the event and interrupt side of a real-time clock. A timebase outside the block supplies a one-cycle seconds strobe and the running seconds count. The block latches two events in a status register. The seconds event is bit 0. The alarm event is bit 1 and fires when the running count equals a programmed 32-bit alarm value. Each event drives its own interrupt line, gated by a mask.

Software reaches the block through a simple register port. The port has a write strobe, an address and write data, and read data is a combinational function of the address. Status bits are cleared by writing ones to them. The mask is changed only through two write-only registers: writing a one to the first unmasks an event, and writing a one to the second masks it. Because the alarm event is set again on every cycle the match holds, a clear issued while the count still equals the alarm value does not take. Software has to retry after the count moves on.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the status reads 0, the mask readback reads 2'b11 (both events masked), the alarm register reads 0, and both interrupt outputs are low.
- R2: A write to offset 0x18 loads all 32 bits of the alarm value, and a read of 0x18 returns that value.
- R3: A cycle with `sec_pulse` high sets status bit 0 at the next clock edge. The mask has no effect on this.
- R4: Status bit 1 is set at every clock edge where `cur_seconds` equals the alarm value. The mask has no effect on this.
- R5: A write to offset 0x20 clears each status bit whose write-data bit is one. Bits written with zero keep their value. The status reads back at 0x20 in bits [1:0].
- R6: If an event occurs in the same cycle as a clear of its bit, the event wins and the bit stays set. The alarm bit therefore cannot be cleared while the match persists.
- R7: Writing a one to bit i at offset 0x28 unmasks event i and leaves the other mask bit unchanged. The mask reads back at 0x24 with bit i = 1 meaning masked.
- R8: Writing a one to bit i at offset 0x2C masks event i and leaves the other mask bit unchanged.
- R9: `irq_sec` is high exactly when status bit 0 is set and event 0 is unmasked. `irq_alarm` is high exactly when status bit 1 is set and event 1 is unmasked. Both are level outputs that follow the registered state.
- R10: Writes to any other offset change nothing. Reads of 0x28, 0x2C and any undefined offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| sec_pulse | input | 1 | One-cycle seconds strobe from the timebase |
| cur_seconds | input | DATA_W (32) | Running seconds count from the timebase |
| irq_sec | output | 1 | Seconds interrupt, level |
| irq_alarm | output | 1 | Alarm interrupt, level |

## Verification
All state in the block is a handful of flops, and each flop is visible at the ports within a cycle. The status and mask values appear on the read port at once, and the interrupt lines follow them combinationally. A wrong status bit, mask bit or alarm value therefore shows up either on an interrupt line in the cycle after the bad update, or on the next read of the affected register. The bench compares the interrupt lines with a behavioural model on every clock. It reads back the registers after each scenario, which covers set-versus-clear precedence and the mask having no effect on latching.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam int NUM_EV   = 2;
  localparam int EV_SEC   = 0;
  localparam int EV_ALARM = 1;

  // register byte offsets
  localparam int OFF_ALARM   = 'h18;
  localparam int OFF_STATUS  = 'h20;
  localparam int OFF_MASK_RD = 'h24;
  localparam int OFF_UNMASK  = 'h28;
  localparam int OFF_MASK    = 'h2C;

  typedef struct packed {
    logic alarm;
    logic clr;
    logic unmask;
    logic mask;
  } rtc_wr_sel_t;

  // event set has priority over a write-one clear
  function automatic logic ev_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // mask bit: 1 = masked; a disable write sets it, an enable write clears it
  function automatic logic mask_next(logic cur, logic unmask, logic mask);
    return mask | (cur & ~unmask);
  endfunction

  function automatic logic irq_level(logic st, logic msk);
    return st & ~msk;
  endfunction

endpackage

// File: rtl/rtc_irq_decode.sv
module rtc_irq_decode
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] alarm_val,
  input  logic [NUM_EV-1:0] status_val,
  input  logic [NUM_EV-1:0] mask_val,
  output rtc_wr_sel_t       wr_sel,
  output logic [DATA_W-1:0] rdata
);

  logic hit_alarm, hit_status, hit_mask_rd, hit_unmask, hit_mask;

  assign hit_alarm   = (reg_addr == ADDR_W'(OFF_ALARM));
  assign hit_status  = (reg_addr == ADDR_W'(OFF_STATUS));
  assign hit_mask_rd = (reg_addr == ADDR_W'(OFF_MASK_RD));
  assign hit_unmask  = (reg_addr == ADDR_W'(OFF_UNMASK));
  assign hit_mask    = (reg_addr == ADDR_W'(OFF_MASK));

  always_comb begin
    wr_sel        = '0;
    wr_sel.alarm  = reg_wr & hit_alarm;
    wr_sel.clr    = reg_wr & hit_status;
    wr_sel.unmask = reg_wr & hit_unmask;
    wr_sel.mask   = reg_wr & hit_mask;
  end

  always_comb begin
    rdata = '0;
    if (hit_alarm)        rdata = alarm_val;
    else if (hit_status)  rdata[NUM_EV-1:0] = status_val;
    else if (hit_mask_rd) rdata[NUM_EV-1:0] = mask_val;
  end

endmodule

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_seconds,
  output logic [DATA_W-1:0] alarm_q,
  output logic              hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  alarm_q <= '0;
    else if (wr) alarm_q <= wdata;
  end

  assign hit = (cur_seconds == alarm_q);

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_set,
  input  logic [NUM_EV-1:0] ev_clr,
  input  logic [NUM_EV-1:0] unmask_bits,
  input  logic [NUM_EV-1:0] mask_bits,
  output logic [NUM_EV-1:0] status_q,
  output logic [NUM_EV-1:0] mask_q,
  output logic [NUM_EV-1:0] irq
);

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
        mask_q[i]   <= 1'b1;
      end else begin
        status_q[i] <= ev_next(status_q[i], ev_set[i], ev_clr[i]);
        mask_q[i]   <= mask_next(mask_q[i], unmask_bits[i], mask_bits[i]);
      end
    end
    assign irq[i] = irq_level(status_q[i], mask_q[i]);
  end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sec_pulse,
  input  logic [DATA_W-1:0] cur_seconds,
  output logic              irq_sec,
  output logic              irq_alarm
);

  rtc_wr_sel_t       wr_sel;
  logic [DATA_W-1:0] alarm_q;
  logic              alarm_hit;
  logic [NUM_EV-1:0] status_q, mask_q, irq_vec;
  logic [NUM_EV-1:0] ev_set, ev_clr, unmask_bits, mask_bits;
  logic [NUM_EV-1:0] wbits;

  assign wbits = reg_wdata[NUM_EV-1:0];

  rtc_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .alarm_val  (alarm_q),
    .status_val (status_q),
    .mask_val   (mask_q),
    .wr_sel     (wr_sel),
    .rdata      (reg_rdata)
  );

  rtc_irq_alarm #(.DATA_W(DATA_W)) u_alarm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr_sel.alarm),
    .wdata       (reg_wdata),
    .cur_seconds (cur_seconds),
    .alarm_q     (alarm_q),
    .hit         (alarm_hit)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_SEC]   = sec_pulse;
    ev_set[EV_ALARM] = alarm_hit;
  end

  assign ev_clr      = wr_sel.clr    ? wbits : '0;
  assign unmask_bits = wr_sel.unmask ? wbits : '0;
  assign mask_bits   = wr_sel.mask   ? wbits : '0;

  rtc_irq_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_set      (ev_set),
    .ev_clr      (ev_clr),
    .unmask_bits (unmask_bits),
    .mask_bits   (mask_bits),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .irq         (irq_vec)
  );

  assign irq_sec   = irq_vec[EV_SEC];
  assign irq_alarm = irq_vec[EV_ALARM];

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              sec_pulse,
  input logic              irq_alarm,
  input logic              alarm_hit,
  input logic [NUM_EV-1:0] status_q,
  input logic [NUM_EV-1:0] mask_q
);

  logic wr_clr, wr_unmask, wr_mask;
  assign wr_clr    = reg_wr && (reg_addr == ADDR_W'(OFF_STATUS));
  assign wr_unmask = reg_wr && (reg_addr == ADDR_W'(OFF_UNMASK));
  assign wr_mask   = reg_wr && (reg_addr == ADDR_W'(OFF_MASK));

  // R3
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> status_q[EV_SEC]);

  // R4
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> status_q[EV_ALARM]);

  // R5
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[EV_SEC] && !sec_pulse) |=> !status_q[EV_SEC]);

  // R7
  unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmask && reg_wdata[EV_ALARM]) |=> !mask_q[EV_ALARM]);

  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && reg_wdata[EV_SEC]) |=> mask_q[EV_SEC]);

  // R9
  alarm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && !mask_q[EV_ALARM] && !(wr_mask && reg_wdata[EV_ALARM]))
      |=> irq_alarm);

endmodule

bind rtc_irq_ctrl rtc_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sec_pulse (sec_pulse),
  .irq_alarm (irq_alarm),
  .alarm_hit (alarm_hit),
  .status_q  (status_q),
  .mask_q    (mask_q)
);

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sec_pulse = 1'b0;
  logic [31:0] cur_seconds = 32'h100;
  logic        irq_sec, irq_alarm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_pulse(sec_pulse),
    .cur_seconds(cur_seconds), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  // behavioural reference
  bit [1:0]  m_st;
  bit [1:0]  m_mk;
  bit [31:0] m_al;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 2'b00; m_mk = 2'b11; m_al = 0;
    end else begin
      bit [1:0] setv;
      setv = {cur_seconds == m_al, sec_pulse};
      if (reg_wr && reg_addr == 8'h20) m_st = m_st & ~reg_wdata[1:0];
      m_st = m_st | setv;
      if (reg_wr && reg_addr == 8'h28) m_mk = m_mk & ~reg_wdata[1:0];
      if (reg_wr && reg_addr == 8'h2C) m_mk = m_mk | reg_wdata[1:0];
      if (reg_wr && reg_addr == 8'h18) m_al = reg_wdata;
    end
  end

  function automatic bit [31:0] model_rd(bit [7:0] a);
    case (a)
      8'h18:   return m_al;
      8'h20:   return {30'd0, m_st};
      8'h24:   return {30'd0, m_mk};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9: interrupt lines compared with the model every cycle
  always @(negedge clk) if (rst_n && !done) begin
    chk({31'd0, irq_sec},   {31'd0, m_st[0] & ~m_mk[0]}, "R9 irq_sec");
    chk({31'd0, irq_alarm}, {31'd0, m_st[1] & ~m_mk[1]}, "R9 irq_alarm");
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata, model_rd(a), {tag, " model"});
    chk(reg_rdata, exp, tag);
  endtask

  task automatic pulse_sec();
    @(negedge clk);
    sec_pulse = 1'b1;
    @(negedge clk);
    sec_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h18, 32'h0, "R1 alarm");
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h24, 32'h3, "R1 mask");
    chk({30'd0, irq_alarm, irq_sec}, 32'h0, "R1 irqs");
    // R2 alarm register
    wr(8'h18, 32'hDEADBEEF);
    rd(8'h18, 32'hDEADBEEF, "R2 alarm rb");
    // R10 undefined offsets
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'h1C, 32'h12345678);
    rd(8'h30, 32'h0, "R10 read 30");
    rd(8'h28, 32'h0, "R10 read 28");
    rd(8'h18, 32'hDEADBEEF, "R10 alarm kept");
    rd(8'h24, 32'h3, "R10 mask kept");
    // R3 seconds latch while masked
    pulse_sec();
    rd(8'h20, 32'h1, "R3 sec latched");
    chk({31'd0, irq_sec}, 32'h0, "R9 masked sec");
    // R5 write zero no effect, write one clears
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R5 zero write");
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R5 cleared");
    // R7 unmask seconds
    wr(8'h28, 32'h1);
    rd(8'h24, 32'h2, "R7 mask rb");
    pulse_sec();
    chk({31'd0, irq_sec}, 32'h1, "R9 irq_sec high");
    // R8 mask again, status kept
    wr(8'h2C, 32'h1);
    rd(8'h24, 32'h3, "R8 mask rb");
    rd(8'h20, 32'h1, "R8 status kept");
    chk({31'd0, irq_sec}, 32'h0, "R8 irq_sec low");
    wr(8'h20, 32'h1);
    // R4 / R6 alarm match persisting
    wr(8'h18, 32'h200);
    wr(8'h28, 32'h2);
    @(negedge clk); cur_seconds = 32'h200;
    repeat (3) @(negedge clk);
    rd(8'h20, 32'h2, "R4 alarm latched");
    chk({31'd0, irq_alarm}, 32'h1, "R9 irq_alarm high");
    wr(8'h20, 32'h2);
    rd(8'h20, 32'h2, "R6 clear loses to match");
    @(negedge clk); cur_seconds = 32'h201;
    wr(8'h20, 32'h2);
    rd(8'h20, 32'h0, "R6 clear after match");
    // R4 latches while masked
    wr(8'h2C, 32'h2);
    @(negedge clk); cur_seconds = 32'h200;
    @(negedge clk); cur_seconds = 32'h202;
    rd(8'h20, 32'h2, "R4 masked latch");
    chk({31'd0, irq_alarm}, 32'h0, "R9 irq_alarm masked");
    // R6 seconds pulse with simultaneous clear
    @(negedge clk);
    sec_pulse = 1'b1; reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h1;
    @(negedge clk);
    sec_pulse = 1'b0; reg_wr = 1'b0;
    rd(8'h20, 32'h3, "R6 sec set wins");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule